// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs the external memory and I/O cycles of a small processor core over one shared address and data bus. The core presents one request: direction, address space (program, data or I/O), a global flag, an address and write data. The block accepts it when idle and then drives the active-low strobe, read enable, write enable and bus request pins, the read/write direction line and the enable of the data output drivers. It returns a one-clock done pulse and, for a read, the captured data word.

Reads with no wait states take one strobe cycle. Every write takes an extra leading cycle in which the data drivers turn on before the strobe falls, so that read and write drivers never share the bus. The strobe phase can be stretched in two ways. A per-space software wait-state count adds a fixed number of cycles. An external ready line, when ready gating is on, holds the cycle until it is seen high. Ready gating is on when the core enables it, and always for a global access to data space, which also pulls bus request low for the whole access. One configuration input makes the read-enable pin carry the inverse of the direction line in place of a read strobe.

Top module: `extbus_ctrl`

## Requirements
- R1: After reset, strb_n, we_n, br_n and rd_n (with rd_inv low) are high, rnw is high, and bus_oe and done are low.
- R2: A read whose selected wait count is 0 and that is not ready-gated holds strb_n low for exactly one cycle. done goes high in the next cycle, and rdata then holds the bus_din value from the last strobe cycle.
- R3: A write first spends one cycle with rnw low, bus_oe high and strb_n high, then its strobe cycles with bus_oe still high. bus_oe is never high while rnw is high. The bus_dout value seen while we_n is low is the request's write data.
- R4: The wait count comes from wait_cfg by the space code: code 0 (program) uses bits [2:0], code 1 (data) uses bits [5:3], codes 2 and 3 (I/O) use bits [8:6]. Without ready gating the strobe phase lasts that count plus one cycles.
- R5: During the strobe phase, sp_sel equals the request's space code and bus_addr equals its address. The I/O space has the same cycle timing as the memory spaces.
- R6: With rd_inv low, rd_n is low only in the strobe cycles of a read. With rd_inv high, rd_n always equals the inverse of rnw.
- R7: With ready gating on, the strobe phase ends only after a cycle in which the wait count has run out and ready is high. Ready held low adds any number of cycles.
- R8: With ready gating on, a selected wait count of 0 is used as 1, so the strobe phase is at least two cycles long.
- R9: A global request to data space (space code 1) drives br_n low in every cycle of the access from its first cycle, and is ready-gated even when rdy_gate_en is low. No other access drives br_n low.
- R10: done is high for exactly one cycle per access. A request presented while an access is in progress is ignored.
- R11: Without ready gating, the ready input has no effect on cycle length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core request, taken when the block is idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | 0 program, 1 data, 2 or 3 I/O |
| req_global | input | 1 | Global access flag |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| wait_cfg | input | 3*WSW | Software wait counts: program, data and I/O fields, low field first |
| rdy_gate_en | input | 1 | Enables ready gating for all accesses |
| rd_inv | input | 1 | rd_n carries the inverse of rnw |
| ready | input | 1 | External ready |
| bus_din | input | DW | Data bus input |
| bus_addr | output | AW | External address |
| bus_dout | output | DW | Data bus output value |
| bus_oe | output | 1 | Data output driver enable |
| strb_n | output | 1 | Cycle strobe, active low |
| rnw | output | 1 | 1 = read or idle, 0 = write |
| rd_n | output | 1 | Read enable, active low |
| we_n | output | 1 | Write enable, active low |
| br_n | output | 1 | Bus request, active low |
| sp_sel | output | 2 | Space of the current access |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Captured read data |

## Verification
The bench uses AW = 10, DW = 16 and WSW = 3, so every one of the eight wait counts can be swept in each of the three spaces, for both reads and writes. Wait fields that are not selected hold different values, so a wrong field choice shows up as a wrong strobe length. The bench's ready responder holds ready low for a chosen number of strobe cycles, so the bench can reach both cases: the software count expiring first, and ready arriving first. This covers the zero-as-one case, the forced gating of global data accesses, and the case where ready is low but ignored.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
    localparam logic [1:0] SP_PROG = 2'd0;
    localparam logic [1:0] SP_DATA = 2'd1;
    localparam logic [1:0] SP_IO   = 2'd2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_STRB = 2'd2
    } phase_e;
endpackage

// File: rtl/extbus_waitsel.sv
module extbus_waitsel import extbus_pkg::*; #(
    parameter int WSW = 3
) (
    input  logic [1:0]       space,
    input  logic             global_acc,
    input  logic             gate_en,
    input  logic [3*WSW-1:0] wait_cfg,
    output logic [WSW-1:0]   wait_n,
    output logic             gated
);
    localparam int NFLD = 3;

    logic [WSW-1:0] fld [NFLD];
    logic [WSW-1:0] pick;

    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        assign fld[g] = wait_cfg[g*WSW +: WSW];
    end

    always_comb begin
        case (space)
            SP_PROG: pick = fld[0];
            SP_DATA: pick = fld[1];
            default: pick = fld[2];
        endcase
        gated  = gate_en | (global_acc && space == SP_DATA);
        wait_n = (gated && pick == '0) ? WSW'(1) : pick;
    end
endmodule

// File: rtl/extbus_seq.sv
module extbus_seq import extbus_pkg::*; #(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int WSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [1:0]     req_space,
    input  logic           req_global,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    input  logic [WSW-1:0] wait_n,
    input  logic           gated,
    input  logic           ready,
    input  logic [DW-1:0]  bus_din,
    output phase_e         phase,
    output logic           acc_wr,
    output logic [1:0]     acc_sp,
    output logic           acc_glob,
    output logic [AW-1:0]  acc_addr,
    output logic [DW-1:0]  acc_wdata,
    output logic [DW-1:0]  rdata,
    output logic           done
);
    typedef struct packed {
        phase_e         ph;
        logic           wr;
        logic [1:0]     sp;
        logic           glob;
        logic           gated;
        logic [WSW-1:0] cnt;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic [DW-1:0]  rdata;
        logic           done;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.wr    = req_write;
                    st_d.sp    = req_space;
                    st_d.glob  = req_global;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.cnt   = wait_n;
                    st_d.gated = gated;
                    st_d.ph    = req_write ? PH_LEAD : PH_STRB;
                end
            end
            PH_LEAD: st_d.ph = PH_STRB;
            PH_STRB: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - WSW'(1);
                end else if (!st_q.gated || ready) begin
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                    if (!st_q.wr) st_d.rdata = bus_din;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase     = st_q.ph;
    assign acc_wr    = st_q.wr;
    assign acc_sp    = st_q.sp;
    assign acc_glob  = st_q.glob;
    assign acc_addr  = st_q.addr;
    assign acc_wdata = st_q.wdata;
    assign rdata     = st_q.rdata;
    assign done      = st_q.done;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != PH_IDLE && req_valid) |=> $stable(st_q.addr));

    // R7
    rdy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && st_q.gated) |-> $past(ready));

    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_STRB && st_q.cnt != '0) |=> (st_q.ph == PH_STRB));
endmodule

// File: rtl/extbus_pins.sv
module extbus_pins import extbus_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  phase_e     phase,
    input  logic       acc_wr,
    input  logic [1:0] acc_sp,
    input  logic       acc_glob,
    input  logic       rd_inv,
    output logic       strb_n,
    output logic       rnw,
    output logic       rd_n,
    output logic       we_n,
    output logic       br_n,
    output logic       bus_oe
);
    logic active, in_strb;

    always_comb begin
        active  = (phase != PH_IDLE);
        in_strb = (phase == PH_STRB);
        rnw     = !(active && acc_wr);
        strb_n  = !in_strb;
        we_n    = !(in_strb && acc_wr);
        rd_n    = rd_inv ? !rnw : !(in_strb && !acc_wr);
        bus_oe  = active && acc_wr;
        br_n    = !(active && acc_glob && acc_sp == SP_DATA);
    end

    // R3
    oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> !rnw);

    // R3
    we_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(bus_oe));

    // R9
    br_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_oe) || $fell(strb_n)) && acc_glob && acc_sp == SP_DATA |-> !br_n);
endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl import extbus_pkg::*; #(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int WSW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_space,
    input  logic             req_global,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [3*WSW-1:0] wait_cfg,
    input  logic             rdy_gate_en,
    input  logic             rd_inv,
    input  logic             ready,
    input  logic [DW-1:0]    bus_din,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_dout,
    output logic             bus_oe,
    output logic             strb_n,
    output logic             rnw,
    output logic             rd_n,
    output logic             we_n,
    output logic             br_n,
    output logic [1:0]       sp_sel,
    output logic             done,
    output logic [DW-1:0]    rdata
);
    logic [WSW-1:0] wait_n;
    logic           gated;
    phase_e         phase;
    logic           acc_wr, acc_glob;
    logic [1:0]     acc_sp;

    extbus_waitsel #(.WSW(WSW)) u_wsel (
        .space      (req_space),
        .global_acc (req_global),
        .gate_en    (rdy_gate_en),
        .wait_cfg   (wait_cfg),
        .wait_n     (wait_n),
        .gated      (gated)
    );

    extbus_seq #(.AW(AW), .DW(DW), .WSW(WSW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_space  (req_space),
        .req_global (req_global),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .wait_n     (wait_n),
        .gated      (gated),
        .ready      (ready),
        .bus_din    (bus_din),
        .phase      (phase),
        .acc_wr     (acc_wr),
        .acc_sp     (acc_sp),
        .acc_glob   (acc_glob),
        .acc_addr   (bus_addr),
        .acc_wdata  (bus_dout),
        .rdata      (rdata),
        .done       (done)
    );

    extbus_pins u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .acc_wr   (acc_wr),
        .acc_sp   (acc_sp),
        .acc_glob (acc_glob),
        .rd_inv   (rd_inv),
        .strb_n   (strb_n),
        .rnw      (rnw),
        .rd_n     (rd_n),
        .we_n     (we_n),
        .br_n     (br_n),
        .bus_oe   (bus_oe)
    );

    assign sp_sel = acc_sp;
endmodule

// File: tb/extbus_ctrl_test.sv
`timescale 1ns/1ps
module extbus_ctrl_test;
    localparam int AW  = 10;
    localparam int DW  = 16;
    localparam int WSW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_global = 1'b0;
    logic [1:0] req_space = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [3*WSW-1:0] wait_cfg = '0;
    logic rdy_gate_en = 1'b0, rd_inv = 1'b0;
    logic ready;
    logic [DW-1:0] bus_din;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout, rdata;
    logic bus_oe, strb_n, rnw, rd_n, we_n, br_n, done;
    logic [1:0] sp_sel;

    int nchk = 0, nfail = 0;
    int rdy_after = 0;
    int sidx = 0;

    always #4 clk = ~clk;

    // responder: ready rises after rdy_after strobe cycles; data is a function of address
    always @(posedge clk) sidx <= strb_n ? 0 : sidx + 1;
    assign ready   = (sidx >= rdy_after);
    assign bus_din = DW'(int'(bus_addr) * 37 + 5);

    extbus_ctrl #(.AW(AW), .DW(DW), .WSW(WSW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_space(req_space), .req_global(req_global), .req_addr(req_addr),
        .req_wdata(req_wdata), .wait_cfg(wait_cfg), .rdy_gate_en(rdy_gate_en),
        .rd_inv(rd_inv), .ready(ready), .bus_din(bus_din), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .strb_n(strb_n), .rnw(rnw),
        .rd_n(rd_n), .we_n(we_n), .br_n(br_n), .sp_sel(sp_sel), .done(done),
        .rdata(rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int field_of(input int cfg, input int sp);
        int idx = (sp >= 2) ? 2 : sp;
        return (cfg >> (WSW * idx)) & ((1 << WSW) - 1);
    endfunction

    task automatic xfer(input bit wr, input int sp, input bit glob, input int addr,
                        input int rdly, input bit probe);
        int f, n, exp_str, n_str, n_lead, to, wcap;
        bit gt, b_oe, b_sp, b_rnw, b_rd, b_we, b_br, exp_rd;
        int wdat = (addr * 13 + 7) & 16'hFFFF;
        f  = field_of(int'(wait_cfg), sp);
        gt = rdy_gate_en || (glob && sp == 1);
        n  = (gt && f == 0) ? 1 : f;
        exp_str = gt ? ((n > rdly) ? n : rdly) + 1 : n + 1;
        @(negedge clk);
        rdy_after = rdly;
        req_valid = 1'b1; req_write = wr; req_space = 2'(sp); req_global = glob;
        req_addr = AW'(addr); req_wdata = DW'(wdat);
        @(negedge clk);
        req_valid = 1'b0;
        n_str = 0; n_lead = 0; to = 0; wcap = -1;
        b_oe = 0; b_sp = 0; b_rnw = 0; b_rd = 0; b_we = 0; b_br = 0;
        while (!done && to < 200) begin
            if (!strb_n) n_str++;
            else if (bus_oe) n_lead++;
            if (bus_oe && rnw) b_oe = 1;
            if (!wr && bus_oe) b_oe = 1;
            if (wr && !strb_n && !bus_oe) b_oe = 1;
            if (!strb_n && (int'(sp_sel) != sp || int'(bus_addr) != addr)) b_sp = 1;
            if (rnw != !wr) b_rnw = 1;
            exp_rd = rd_inv ? !rnw : !(!strb_n && !wr);
            if (rd_n != exp_rd) b_rd = 1;
            if (we_n != !(!strb_n && wr)) b_we = 1;
            if (!we_n) wcap = int'(bus_dout);
            if (br_n != !(glob && sp == 1)) b_br = 1;
            req_valid = (probe && n_str == 1);
            req_addr  = probe ? AW'(addr ^ 1) : AW'(addr);
            @(negedge clk);
            to++;
        end
        req_valid = 1'b0;
        chk(done == 1'b1, "R10 done reached", int'(done), 1);
        chk(n_str == exp_str, "R2/R4/R7/R8/R11 strobe length", n_str, exp_str);
        chk(n_lead == (wr ? 1 : 0), "R3 lead cycles", n_lead, wr ? 1 : 0);
        chk(!b_oe, "R3 output enable vs direction", b_oe, 0);
        chk(!b_sp, "R5 space and address", b_sp, 0);
        chk(!b_rnw, "R3 rnw level", b_rnw, 0);
        chk(!b_rd, "R6 rd_n behaviour", b_rd, 0);
        chk(!b_we, "R3 we_n behaviour", b_we, 0);
        chk(!b_br, "R9 br_n behaviour", b_br, 0);
        if (wr) chk(wcap == wdat, "R3 write data", wcap, wdat);
        else    chk(int'(rdata) == ((addr * 37 + 5) & 16'hFFFF), "R2 read data",
                    int'(rdata), (addr * 37 + 5) & 16'hFFFF);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
        if (probe) begin
            @(negedge clk);
            chk(strb_n == 1'b1 && bus_oe == 1'b0, "R10 busy request ignored",
                int'(strb_n), 1);
        end
    endtask

    function automatic logic [3*WSW-1:0] make_cfg(input int sp, input int w);
        logic [3*WSW-1:0] c = '0;
        for (int g = 0; g < 3; g++)
            c[g*WSW +: WSW] = WSW'((g == ((sp >= 2) ? 2 : sp)) ? w : (w + 3) % 8);
        return c;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int a = 3;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(strb_n && we_n && br_n && rd_n, "R1 idle strobes high",
            int'({strb_n, we_n, br_n, rd_n}), 15);
        chk(rnw && !bus_oe && !done, "R1 rnw/oe/done", int'({rnw, bus_oe, done}), 4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(strb_n && !bus_oe && !done, "R1 after release", int'({strb_n, bus_oe, done}), 4);

        // R4 R5 R2 R3: every space x wait count x direction, no gating
        for (int sp = 0; sp < 3; sp++)
            for (int w = 0; w < 8; w++)
                for (int wr = 0; wr < 2; wr++) begin
                    wait_cfg = make_cfg(sp, w);
                    a = (a * 7 + 11) % 1024;
                    xfer(wr[0], sp, 1'b0, a, 0, 1'b0);
                end
        // space code 3 uses I/O field
        wait_cfg = make_cfg(2, 5);
        xfer(1'b0, 3, 1'b0, 77, 0, 1'b0);

        // R11 ready low but ungated
        wait_cfg = make_cfg(1, 2);
        xfer(1'b0, 1, 1'b0, 100, 6, 1'b0);
        xfer(1'b1, 0, 1'b1, 101, 6, 1'b0);

        // R7 R8 ready gating sweep
        rdy_gate_en = 1'b1;
        for (int w = 0; w < 4; w++)
            for (int r = 0; r < 5; r++) begin
                wait_cfg = make_cfg(1, w);
                xfer(1'(r & 1), 1, 1'b0, 200 + w * 8 + r, r, 1'b0);
            end
        wait_cfg = make_cfg(2, 0);
        xfer(1'b0, 2, 1'b0, 300, 0, 1'b0);

        // R9 global data access forces gating and bus request
        rdy_gate_en = 1'b0;
        for (int w = 0; w < 3; w++)
            for (int r = 0; r < 4; r++) begin
                wait_cfg = make_cfg(1, w);
                xfer(1'(w & 1), 1, 1'b1, 400 + w * 4 + r, r, 1'b0);
            end
        wait_cfg = make_cfg(2, 1);
        xfer(1'b0, 2, 1'b1, 500, 5, 1'b0);

        // R6 inverted read-enable mode
        rd_inv = 1'b1;
        wait_cfg = make_cfg(0, 1);
        xfer(1'b0, 0, 1'b0, 600, 0, 1'b0);
        xfer(1'b1, 0, 1'b0, 601, 0, 1'b0);
        @(negedge clk);
        chk(rd_n == 1'b0, "R6 idle inverted rd_n", int'(rd_n), 0);
        rd_inv = 1'b0;

        // R10 request while busy is ignored
        wait_cfg = make_cfg(1, 4);
        xfer(1'b0, 1, 1'b0, 700, 0, 1'b1);
        xfer(1'b1, 1, 1'b0, 702, 0, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule